// File: doc/BRIEF.md
# General Register ALU Datapath

This block is the execution core of a small processor. It holds seven general registers and one ALU, and it carries out one micro-operation per clock. A 14-bit control word arrives on a port each cycle. Its fields choose the two ALU operands, the ALU function and the register, if any, that captures the result. Operand code zero selects an external data input instead of a register. A sequencer outside the block supplies the words, so the block needs no fetch logic, no decode logic and no memory port.

The ALU result is always visible on `data_out` as a combinational function of the current control word and the register contents. The selected destination register is written on the next rising clock edge. The four status flags are captured on every rising edge. They describe the result of the cycle that just ended.

Top module: `gra_datapath`

## Requirements
- R1: The control word is split from its most significant bit down as source-A select [13:11], source-B select [10:8], destination select [7:5] and opcode [4:0]. A source select of 1 to 7 picks register R1 to R7, and a source select of 0 picks `data_in`.
- R2: A destination select of 1 to 7 loads the ALU result into R1 to R7 on the rising clock edge. A destination select of 0 leaves all seven registers unchanged.
- R3: `data_out` is the combinational ALU result of the control word and operands present in the same cycle, before the clock edge that stores it.
- R4: The opcodes are 00001 A+1, 00010 A+B, 00101 A-B and 00110 A-1. All four use one adder that computes A + X + cin, with X/cin equal to 0/1, B/0, ~B/1 and all-ones/0 respectively. C is the carry out of the top bit, so for subtraction C=1 means no borrow.
- R5: The opcodes are 01000 A AND B, 01010 A OR B, 01100 A XOR B and 01110 NOT A.
- R6: Opcode 10000 shifts A right by one and opcode 11000 shifts A left by one. The vacated bit is 0, and C takes the bit that was shifted out.
- R7: Opcode 00000 passes A unchanged, and every opcode not listed in R4 to R6 also passes A unchanged.
- R8: The flags are updated on every rising clock edge from that cycle's result. S is the result's top bit and Z is 1 when every result bit is 0.
- R9: Transfer, logic and unlisted opcodes clear both C and V. Shift opcodes clear V.
- R10: For the adder opcodes, V is the XOR of the carry into the top bit and the carry out of the top bit.
- R11: Selecting the same register as source A, source B and destination with the XOR opcode clears that register.
- R12: While reset (`rst_n` low, asynchronous) is active, all seven registers and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register and flag updates happen on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 14 | Micro-operation: source A, source B, destination, opcode |
| data_in | input | DATA_W | External operand, selected by source code 0 |
| data_out | output | DATA_W | Combinational ALU result |
| flag_c | output | 1 | Registered carry / shifted-out bit |
| flag_s | output | 1 | Registered sign (top result bit) |
| flag_z | output | 1 | Registered zero indication |
| flag_v | output | 1 | Registered signed overflow |

## Verification
The registers can only be seen through the ALU. The bench therefore reads each register back by issuing a transfer with destination code 0, and it checks source B through an add against a zero input. The hardest cases to reach are the carry and overflow corners. These include an increment wrapping to zero, a decrement of zero, and a signed overflow on both add and subtract. Reaching them requires first steering exact boundary values (0x00, 0x01, 0x7F, 0x80, 0xFF) into registers through the input port. A flag-setting operation is then placed directly before a logic operation, which shows that C and V are cleared on the very next edge.

// File: rtl/gra_pkg.sv
`timescale 1ns/1ps
package gra_pkg;

   localparam int SEL_W = 3;
   localparam int OPR_W = 5;
   localparam int CTRL_W = 3 * SEL_W + OPR_W;

   typedef enum logic [OPR_W-1:0] {
      OP_PASS = 5'b00000,
      OP_INC  = 5'b00001,
      OP_ADD  = 5'b00010,
      OP_SUB  = 5'b00101,
      OP_DEC  = 5'b00110,
      OP_AND  = 5'b01000,
      OP_OR   = 5'b01010,
      OP_XOR  = 5'b01100,
      OP_NOT  = 5'b01110,
      OP_SHR  = 5'b10000,
      OP_SHL  = 5'b11000
   } alu_op_e;

   typedef struct packed {
      logic [SEL_W-1:0] src_a;
      logic [SEL_W-1:0] src_b;
      logic [SEL_W-1:0] dest;
      logic [OPR_W-1:0] opr;
   } ctrl_t;

   function automatic logic op_uses_adder(input logic [OPR_W-1:0] op);
      return (op == OP_INC) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_DEC);
   endfunction

   function automatic logic op_is_shift(input logic [OPR_W-1:0] op);
      return (op == OP_SHR) || (op == OP_SHL);
   endfunction

endpackage

// File: rtl/gra_dest_decode.sv
`timescale 1ns/1ps
module gra_dest_decode #(
   parameter int SEL_W = 3,
   localparam int NREG = (1 << SEL_W) - 1
) (
   input  logic [SEL_W-1:0] dest_sel,
   output logic [NREG-1:0]  wr_en
);

   for (genvar i = 0; i < NREG; i++) begin : g_dec
      assign wr_en[i] = (dest_sel == SEL_W'(i + 1));
   end

endmodule

// File: rtl/gra_regfile.sv
`timescale 1ns/1ps
module gra_regfile #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 3,
   localparam int NREG  = (1 << SEL_W) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NREG-1:0]   wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  sel_a,
   input  logic [SEL_W-1:0]  sel_b,
   input  logic [DATA_W-1:0] ext_in,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);

   logic [DATA_W-1:0] regs_q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs_q[i] <= '0;
         end else if (wr_en[i]) begin
            regs_q[i] <= wr_data;
         end
      end
   end

   always_comb begin
      opnd_a = ext_in;
      opnd_b = ext_in;
      for (int k = 0; k < NREG; k++) begin
         if (sel_a == SEL_W'(k + 1)) opnd_a = regs_q[k];
         if (sel_b == SEL_W'(k + 1)) opnd_b = regs_q[k];
      end
   end

endmodule

// File: rtl/gra_alu.sv
`timescale 1ns/1ps
module gra_alu
   import gra_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic [OPR_W-1:0]  opr,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   output logic [DATA_W-1:0] result,
   output logic              carry,
   output logic              ovf
);

   logic [DATA_W-1:0] add_x;
   logic              add_cin;
   logic [DATA_W:0]   sum_full;
   logic [DATA_W-1:0] sum_low;
   logic              carry_into_msb;

   always_comb begin
      unique case (opr)
         OP_INC:  begin add_x = '0;  add_cin = 1'b1; end
         OP_ADD:  begin add_x = b;   add_cin = 1'b0; end
         OP_SUB:  begin add_x = ~b;  add_cin = 1'b1; end
         OP_DEC:  begin add_x = '1;  add_cin = 1'b0; end
         default: begin add_x = '0;  add_cin = 1'b0; end
      endcase
   end

   assign sum_full = {1'b0, a} + {1'b0, add_x} + {{DATA_W{1'b0}}, add_cin};
   assign sum_low  = {1'b0, a[DATA_W-2:0]} + {1'b0, add_x[DATA_W-2:0]}
                   + {{(DATA_W-1){1'b0}}, add_cin};
   assign carry_into_msb = sum_low[DATA_W-1];

   always_comb begin
      result = a;
      carry  = 1'b0;
      ovf    = 1'b0;
      if (op_uses_adder(opr)) begin
         result = sum_full[DATA_W-1:0];
         carry  = sum_full[DATA_W];
         ovf    = sum_full[DATA_W] ^ carry_into_msb;
      end else begin
         case (opr)
            OP_AND: result = a & b;
            OP_OR:  result = a | b;
            OP_XOR: result = a ^ b;
            OP_NOT: result = ~a;
            OP_SHR: begin
               result = {1'b0, a[DATA_W-1:1]};
               carry  = a[0];
            end
            OP_SHL: begin
               result = {a[DATA_W-2:0], 1'b0};
               carry  = a[DATA_W-1];
            end
            default: result = a;
         endcase
      end
   end

endmodule

// File: rtl/gra_datapath.sv
`timescale 1ns/1ps
module gra_datapath
   import gra_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [13:0]       ctrl_word,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              flag_c,
   output logic              flag_s,
   output logic              flag_z,
   output logic              flag_v
);

   localparam int NREG = (1 << SEL_W) - 1;

   if (DATA_W < 2) begin : g_bad_width
      $error("gra_datapath: DATA_W must be at least 2");
   end
   if (CTRL_W != 14) begin : g_bad_ctrl
      $error("gra_datapath: control word layout must total 14 bits");
   end

   ctrl_t             cw;
   logic [NREG-1:0]   wr_en;
   logic [DATA_W-1:0] opnd_a;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] alu_res;
   logic              alu_carry;
   logic              alu_ovf;

   assign cw = ctrl_t'(ctrl_word);

   gra_dest_decode #(.SEL_W(SEL_W)) u_dec (
      .dest_sel (cw.dest),
      .wr_en    (wr_en)
   );

   gra_regfile #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (alu_res),
      .sel_a   (cw.src_a),
      .sel_b   (cw.src_b),
      .ext_in  (data_in),
      .opnd_a  (opnd_a),
      .opnd_b  (opnd_b)
   );

   gra_alu #(.DATA_W(DATA_W)) u_alu (
      .opr    (cw.opr),
      .a      (opnd_a),
      .b      (opnd_b),
      .result (alu_res),
      .carry  (alu_carry),
      .ovf    (alu_ovf)
   );

   assign data_out = alu_res;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_c <= 1'b0;
         flag_s <= 1'b0;
         flag_z <= 1'b0;
         flag_v <= 1'b0;
      end else begin
         flag_c <= alu_carry;
         flag_s <= alu_res[DATA_W-1];
         flag_z <= (alu_res == '0);
         flag_v <= alu_ovf;
      end
   end

endmodule

// File: rtl/gra_datapath_chk.sv
`timescale 1ns/1ps
module gra_datapath_chk
   import gra_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [13:0]       ctrl_word,
   input logic [DATA_W-1:0] data_in,
   input logic [DATA_W-1:0] data_out,
   input logic              flag_c,
   input logic              flag_s,
   input logic              flag_z,
   input logic              flag_v
);

   logic [SEL_W-1:0] sa, sb, sd;
   logic [OPR_W-1:0] op;
   logic             op_clears_cv;
   logic             op_listed;

   assign sa = ctrl_word[13:11];
   assign sb = ctrl_word[10:8];
   assign sd = ctrl_word[7:5];
   assign op = ctrl_word[4:0];
   assign op_listed = op_uses_adder(op) || op_is_shift(op) || (op == OP_PASS)
                    || (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_NOT);
   assign op_clears_cv = !op_uses_adder(op) && !op_is_shift(op);

   assert_zero_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (flag_z == ($past(data_out) == '0)));

   assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (flag_s == $past(data_out[DATA_W-1])));

   assert_cv_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(op_clears_cv)) |-> (!flag_c && !flag_v));

   assert_input_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (sa == '0 && op == OP_PASS) |-> (data_out == data_in));

   assert_unlisted_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sa == '0 && !op_listed) |-> (data_out == data_in));

   assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(sd) != '0 && sa == $past(sd) && op == OP_PASS)
      |-> (data_out == $past(data_out)));

   assert_self_xor_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sa == sb && op == OP_XOR) |-> (data_out == '0));

endmodule

bind gra_datapath gra_datapath_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ctrl_word (ctrl_word),
   .data_in   (data_in),
   .data_out  (data_out),
   .flag_c    (flag_c),
   .flag_s    (flag_s),
   .flag_z    (flag_z),
   .flag_v    (flag_v)
);

// File: tb/gra_datapath_test.sv
`timescale 1ns/1ps
module gra_datapath_test;

   localparam logic [4:0] O_PASS = 5'b00000, O_INC = 5'b00001, O_ADD = 5'b00010,
                          O_SUB = 5'b00101, O_DEC = 5'b00110, O_AND = 5'b01000,
                          O_OR = 5'b01010, O_XOR = 5'b01100, O_NOT = 5'b01110,
                          O_SHR = 5'b10000, O_SHL = 5'b11000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [13:0] ctrl_word = '0;
   logic [7:0] data_in = '0;
   logic [7:0] data_out;
   logic       flag_c, flag_s, flag_z, flag_v;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   logic [7:0] m [1:7];

   always #2.5 clk = ~clk;

   gra_datapath #(.DATA_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .data_in(data_in),
      .data_out(data_out), .flag_c(flag_c), .flag_s(flag_s),
      .flag_z(flag_z), .flag_v(flag_v)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // returns {C, V, result}
   function automatic logic [9:0] model(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b);
      logic [7:0] x; logic cin; logic [8:0] s; logic [7:0] lo;
      case (op)
         O_INC, O_ADD, O_SUB, O_DEC: begin
            x   = (op == O_INC) ? 8'h00 : (op == O_ADD) ? b : (op == O_SUB) ? ~b : 8'hFF;
            cin = (op == O_INC) || (op == O_SUB);
            s   = {1'b0, a} + {1'b0, x} + {8'h00, cin};
            lo  = {1'b0, a[6:0]} + {1'b0, x[6:0]} + {7'h00, cin};
            return {s[8], s[8] ^ lo[7], s[7:0]};
         end
         O_AND: return {2'b00, a & b};
         O_OR:  return {2'b00, a | b};
         O_XOR: return {2'b00, a ^ b};
         O_NOT: return {2'b00, ~a};
         O_SHR: return {a[0], 1'b0, 1'b0, a[7:1]};
         O_SHL: return {a[7], 1'b0, a[6:0], 1'b0};
         default: return {2'b00, a};
      endcase
   endfunction

   task automatic run(input logic [2:0] sa, input logic [2:0] sb, input logic [2:0] sd,
                      input logic [4:0] op, input logic [7:0] din, input string tag);
      logic [7:0] a, b; logic [9:0] e;
      a = (sa == 0) ? din : m[sa];
      b = (sb == 0) ? din : m[sb];
      e = model(op, a, b);
      @(negedge clk);
      ctrl_word = {sa, sb, sd, op};
      data_in = din;
      #1;
      chk(data_out === e[7:0], {tag, " result"}, 32'(data_out), 32'(e[7:0]));
      @(posedge clk);
      #1;
      chk({flag_c, flag_v, flag_s, flag_z} === {e[9], e[8], e[7], e[7:0] == 8'h00},
          {tag, " flags CVSZ"}, 32'({flag_c, flag_v, flag_s, flag_z}),
          32'({e[9], e[8], e[7], e[7:0] == 8'h00}));
      if (sd != 0) m[sd] = e[7:0];
   endtask

   task automatic load(input logic [2:0] r, input logic [7:0] v);
      run(3'd0, 3'd0, r, O_PASS, v, "R1 load");
   endtask

   task automatic test_reset;
      chk({flag_c, flag_v, flag_s, flag_z} === 4'b0000, "R12 flags at reset",
          32'({flag_c, flag_v, flag_s, flag_z}), 0);
      for (int i = 1; i <= 7; i++) run(3'(i), 3'd0, 3'd0, O_PASS, 8'hA5, "R12 reg read");
   endtask

   task automatic test_select;
      for (int i = 1; i <= 7; i++) load(3'(i), 8'(8'h11 * i));
      for (int i = 1; i <= 7; i++) run(3'(i), 3'd0, 3'd0, O_PASS, 8'h00, "R1 source A");
      for (int i = 1; i <= 7; i++) run(3'd0, 3'(i), 3'd0, O_ADD, 8'h00, "R1 source B");
      run(3'd0, 3'd0, 3'd0, O_PASS, 8'h3C, "R1 input path");
   endtask

   task automatic test_dest_none;
      run(3'd1, 3'd2, 3'd0, O_ADD, 8'h00, "R2 no write");
      run(3'd0, 3'd0, 3'd0, O_NOT, 8'h0F, "R2 no write");
      for (int i = 1; i <= 7; i++) run(3'(i), 3'd0, 3'd0, O_PASS, 8'h00, "R2 regs kept");
      run(3'd1, 3'd2, 3'd3, O_ADD, 8'h00, "R3 comb result");
      run(3'd3, 3'd0, 3'd0, O_PASS, 8'h00, "R2 written after edge");
   endtask

   task automatic test_arith;
      load(3'd1, 8'hFF); load(3'd2, 8'h00); load(3'd3, 8'h35); load(3'd4, 8'h12);
      run(3'd1, 3'd0, 3'd5, O_INC, 8'h00, "R4 inc wrap");
      run(3'd2, 3'd0, 3'd6, O_DEC, 8'h00, "R4 dec zero");
      run(3'd3, 3'd4, 3'd7, O_ADD, 8'h00, "R4 add");
      run(3'd3, 3'd4, 3'd7, O_SUB, 8'h00, "R4 sub no borrow");
      run(3'd4, 3'd3, 3'd7, O_SUB, 8'h00, "R4 sub borrow");
      run(3'd3, 3'd3, 3'd0, O_SUB, 8'h00, "R4 sub equal");
      run(3'd3, 3'd0, 3'd0, O_DEC, 8'h00, "R4 dec nonzero");
   endtask

   task automatic test_overflow;
      load(3'd1, 8'h7F); load(3'd2, 8'h01); load(3'd3, 8'h80);
      run(3'd1, 3'd2, 3'd0, O_ADD, 8'h00, "R10 add pos ovf");
      run(3'd3, 3'd2, 3'd0, O_SUB, 8'h00, "R10 sub neg ovf");
      run(3'd1, 3'd0, 3'd0, O_INC, 8'h00, "R10 inc ovf");
      run(3'd3, 3'd0, 3'd0, O_DEC, 8'h00, "R10 dec ovf");
      run(3'd3, 3'd3, 3'd0, O_ADD, 8'h00, "R10 add carry+ovf");
   endtask

   task automatic test_logic;
      load(3'd1, 8'hC3); load(3'd2, 8'hA5);
      run(3'd1, 3'd2, 3'd3, O_AND, 8'h00, "R5 and");
      run(3'd1, 3'd2, 3'd4, O_OR, 8'h00, "R5 or");
      run(3'd1, 3'd2, 3'd5, O_XOR, 8'h00, "R5 xor");
      run(3'd1, 3'd0, 3'd6, O_NOT, 8'h00, "R5 not");
      load(3'd7, 8'hFF);
      run(3'd7, 3'd7, 3'd0, O_ADD, 8'h00, "R9 set carry");
      run(3'd7, 3'd7, 3'd0, O_AND, 8'h00, "R9 logic clears CV");
      run(3'd3, 3'd2, 3'd0, O_SUB, 8'h00, "R9 set flags");
      run(3'd1, 3'd0, 3'd0, O_PASS, 8'h00, "R9 pass clears CV");
   endtask

   task automatic test_shift;
      load(3'd1, 8'h81); load(3'd2, 8'h40);
      run(3'd1, 3'd0, 3'd3, O_SHR, 8'h00, "R6 shr out1");
      run(3'd1, 3'd0, 3'd4, O_SHL, 8'h00, "R6 shl out1");
      run(3'd2, 3'd0, 3'd5, O_SHL, 8'h00, "R6 shl to sign");
      run(3'd2, 3'd0, 3'd0, O_SHR, 8'h00, "R6 shr out0");
      run(3'd2, 3'd2, 3'd0, O_SHL, 8'h00, "R6 shl V clear");
   endtask

   task automatic test_unlisted;
      load(3'd6, 8'h5A); load(3'd7, 8'h0F);
      run(3'd6, 3'd7, 3'd1, 5'b00011, 8'h00, "R7 op 00011");
      run(3'd7, 3'd6, 3'd2, 5'b00111, 8'h00, "R7 op 00111");
      run(3'd6, 3'd7, 3'd0, 5'b11111, 8'h00, "R7 op 11111");
      run(3'd0, 3'd6, 3'd0, 5'b10100, 8'hE1, "R7 op 10100");
      run(3'd1, 3'd0, 3'd0, O_PASS, 8'h00, "R7 reg written");
   endtask

   task automatic test_clear;
      load(3'd5, 8'h9E);
      run(3'd5, 3'd5, 3'd5, O_XOR, 8'h00, "R11 self xor");
      run(3'd5, 3'd0, 3'd0, O_PASS, 8'h00, "R11 reg cleared");
   endtask

   task automatic test_reset_again;
      load(3'd4, 8'h77);
      run(3'd1, 3'd1, 3'd0, O_ADD, 8'h00, "R12 flags before reset");
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk({flag_c, flag_v, flag_s, flag_z} === 4'b0000, "R12 flags reset mid-run",
          32'({flag_c, flag_v, flag_s, flag_z}), 0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 1; i <= 7; i++) m[i] = 8'h00;
      for (int i = 1; i <= 7; i++) run(3'(i), 3'd0, 3'd0, O_PASS, 8'h00, "R12 regs after reset");
   endtask

   initial begin
      for (int i = 1; i <= 7; i++) m[i] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_select();
      test_dest_none();
      test_arith();
      test_overflow();
      test_logic();
      test_shift();
      test_unlisted();
      test_clear();
      test_reset_again();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=complete");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule